// File: doc/BRIEF.md
# Timecode Indirect Register Host Port

This block gives a host processor access to a timecode engine through a byte-wide port with three directly decoded locations. Location 1 is a read-only status byte. It packs the live states of two input pins, the receiver lock and direction flags, and the video lock, field and frame flags. Location 2 is a pointer register. It holds a 6-bit index and an auto-increment enable. Location 3 is a data window onto an indirect space of 57 byte registers, and every access to it goes to the register that the pointer currently selects.

The indirect space has two kinds of register. The first eight are read-only and show the received 64-bit timecode word, which the receiver drives in directly. The remaining registers are read/write storage. Their contents leave the block as one flat vector that the transmitter and other consumers read. An access is one host strobe, however many clocks it is held. The access begins on the first clock with the strobe high, and any write takes effect at that edge. The access ends on the first clock with the strobe low again, and that is when the pointer advances if auto-increment is enabled.

Top module: `tc_hostport`

## Requirements
- R1: After reset the pointer index is 0, auto-increment is 0 and every read/write indirect register holds 0x00.
- R2: Reading direct address 1 returns the status byte. Bit 0 is the frame pin, bit 1 the click pin, bit 2 receiver lock, bit 3 code direction, bit 4 reads 0, bit 5 video lock, bit 6 field and bit 7 frame. The status byte follows the inputs combinationally.
- R3: A write to direct address 2 loads the index from data bits 5..0 and auto-increment from bit 7. Reading address 2 returns {auto-increment, 0, index}, so bit 6 always reads 0.
- R4: A read of direct address 3 returns indirect register [index]. Registers 0..7 show byte k of the received word (bits 8k+7..8k), with timecode bit 0 in the LSB of register 0.
- R5: A write through direct address 3 to an index from 8 to 56 stores the byte. The byte appears in byte (index-8) of the write-data vector on the clock edge where the strobe is first seen high.
- R6: A write through the data window to indices 0..7 leaves every stored register unchanged.
- R7: An index of 57 or above reads as 0x00 through the data window, and writes to it change nothing.
- R8: With auto-increment 1, each data-window strobe (read or write) advances the index by exactly one on the first clock after the strobe falls, whatever the strobe length. With auto-increment 0, the index holds.
- R9: Advancing from index 63 wraps the index to 0.
- R10: Direct address 0 reads 0x00. Writes to addresses 0 and 1 are ignored. Strobes to addresses 0, 1 and 2 never advance the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_stb | input | 1 | Host access strobe, one access per high period |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Direct address (1 status, 2 pointer, 3 data window) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from host_addr and pointer |
| pin_frame | input | 1 | Frame pin state |
| pin_click | input | 1 | Click pin state |
| rx_lock | input | 1 | Receiver locked |
| rx_dir | input | 1 | Receiver code direction, 1 = backward |
| vid_lock | input | 1 | Video lock |
| vid_field | input | 1 | Video field flag |
| vid_frame | input | 1 | Video frame flag |
| rx_word | input | 64 | Received timecode word, backs indirect registers 0..7 |
| tx_flat | output | 392 | Read/write indirect registers 8..56, byte k = register 8+k |

## Verification
Two things can happen in the same access: a write is refused and the pointer still advances. The bench provokes this with an auto-incrementing data-window write to a read-only index and to an index beyond the populated range. On every clock it compares the write-data vector with its model, which must stay unchanged, and it checks separately that the index still moves on by one. In a second case, the received word changes while a data-window read of a read-only register is held open. The read is judged against the new word, and the pointer must advance only once when the strobe ends.

// File: rtl/tc_hp_pkg.sv
package tc_hp_pkg;

  localparam int IDX_W  = 6;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    DA_NONE = 2'd0,
    DA_STAT = 2'd1,
    DA_PTR  = 2'd2,
    DA_WIN  = 2'd3
  } dir_addr_e;

  typedef struct packed {
    logic vid_frame;
    logic vid_field;
    logic vid_lock;
    logic rsvd;
    logic rx_dir;
    logic rx_lock;
    logic pin_click;
    logic pin_frame;
  } status_t;

  // next pointer index; natural wrap from the top of the 6-bit range
  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] cur);
    return cur + IDX_W'(1);
  endfunction

  // pointer readback byte: enable on top, reserved bit zero, index below
  function automatic logic [DATA_W-1:0] ptr_byte(input logic ai,
                                                input logic [IDX_W-1:0] idx);
    return {ai, 1'b0, idx};
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic frm_pin,
                                                   input logic clk_pin,
                                                   input logic lock,
                                                   input logic dir,
                                                   input logic vlock,
                                                   input logic fld,
                                                   input logic frm);
    status_t s;
    s.pin_frame = frm_pin;
    s.pin_click = clk_pin;
    s.rx_lock   = lock;
    s.rx_dir    = dir;
    s.rsvd      = 1'b0;
    s.vid_lock  = vlock;
    s.vid_field = fld;
    s.vid_frame = frm;
    return s;
  endfunction

endpackage

// File: rtl/tc_hp_strobe.sv
module tc_hp_strobe
  import tc_hp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  logic [1:0] addr,
  output logic       acc_start,
  output logic       acc_end,
  output logic       win_done
);

  logic stb_q;
  logic win_q;

  assign acc_start = stb & ~stb_q;
  assign acc_end   = ~stb & stb_q;
  assign win_done  = acc_end & win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      win_q <= 1'b0;
    end else begin
      stb_q <= stb;
      if (acc_start)
        win_q <= (addr == DA_WIN);
      else if (acc_end)
        win_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tc_hp_pointer.sv
module tc_hp_pointer
  import tc_hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              step,
  output logic [IDX_W-1:0]  idx,
  output logic              ai
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      ai  <= 1'b0;
    end else if (load) begin
      idx <= load_byte[IDX_W-1:0];
      ai  <= load_byte[DATA_W-1];
    end else if (step && ai) begin
      idx <= idx_step(idx);
    end
  end

endmodule

// File: rtl/tc_hp_regfile.sv
module tc_hp_regfile
  import tc_hp_pkg::*;
#(
  parameter int NUM_REGS = 57,
  parameter int RO_REGS  = 8,
  localparam int WR_REGS = NUM_REGS - RO_REGS
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          idx,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [RO_REGS*DATA_W-1:0] ro_flat,
  output logic [DATA_W-1:0]         rd_byte,
  output logic [WR_REGS*DATA_W-1:0] wr_flat
);

  logic [DATA_W-1:0] store_q [WR_REGS];

  for (genvar k = 0; k < WR_REGS; k++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(RO_REGS + k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        store_q[k] <= '0;
      else if (wr_en && idx == MY_IDX)
        store_q[k] <= wdata;
    end
    assign wr_flat[k*DATA_W +: DATA_W] = store_q[k];
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < RO_REGS; k++)
      if (idx == IDX_W'(k)) rd_byte = ro_flat[k*DATA_W +: DATA_W];
    for (int k = 0; k < WR_REGS; k++)
      if (idx == IDX_W'(RO_REGS + k)) rd_byte = store_q[k];
  end

endmodule

// File: rtl/tc_hostport.sv
module tc_hostport
  import tc_hp_pkg::*;
#(
  parameter int NUM_REGS = 57,
  parameter int RO_REGS  = 8,
  localparam int WR_REGS = NUM_REGS - RO_REGS
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_stb,
  input  logic                      host_we,
  input  logic [1:0]                host_addr,
  input  logic [DATA_W-1:0]         host_wdata,
  output logic [DATA_W-1:0]         host_rdata,
  input  logic                      pin_frame,
  input  logic                      pin_click,
  input  logic                      rx_lock,
  input  logic                      rx_dir,
  input  logic                      vid_lock,
  input  logic                      vid_field,
  input  logic                      vid_frame,
  input  logic [RO_REGS*DATA_W-1:0] rx_word,
  output logic [WR_REGS*DATA_W-1:0] tx_flat
);

  // named internal events, observed by the bound checker
  logic             acc_start;
  logic             acc_end;
  logic             win_done;
  logic             ptr_wr;
  logic             win_wr;
  logic [IDX_W-1:0] ptr_idx;
  logic             ptr_ai;
  logic [DATA_W-1:0] win_byte;
  logic [DATA_W-1:0] stat_byte;

  tc_hp_strobe u_stb (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (host_stb),
    .addr      (host_addr),
    .acc_start (acc_start),
    .acc_end   (acc_end),
    .win_done  (win_done)
  );

  assign ptr_wr = acc_start & host_we & (host_addr == DA_PTR);
  assign win_wr = acc_start & host_we & (host_addr == DA_WIN);

  tc_hp_pointer u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ptr_wr),
    .load_byte (host_wdata),
    .step      (win_done),
    .idx       (ptr_idx),
    .ai        (ptr_ai)
  );

  tc_hp_regfile #(
    .NUM_REGS (NUM_REGS),
    .RO_REGS  (RO_REGS)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (win_wr),
    .idx     (ptr_idx),
    .wdata   (host_wdata),
    .ro_flat (rx_word),
    .rd_byte (win_byte),
    .wr_flat (tx_flat)
  );

  assign stat_byte = pack_status(pin_frame, pin_click, rx_lock, rx_dir,
                                 vid_lock, vid_field, vid_frame);

  always_comb begin
    unique case (dir_addr_e'(host_addr))
      DA_STAT: host_rdata = stat_byte;
      DA_PTR:  host_rdata = ptr_byte(ptr_ai, ptr_idx);
      DA_WIN:  host_rdata = win_byte;
      default: host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tc_hostport_chk.sv
module tc_hostport_chk #(
  parameter int NUM_REGS = 57,
  parameter int RO_REGS  = 8,
  parameter int FLAT_W   = 392
)(
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [1:0]        host_addr,
  input logic [7:0]        host_wdata,
  input logic [7:0]        host_rdata,
  input logic              pin_frame,
  input logic              pin_click,
  input logic              rx_lock,
  input logic              rx_dir,
  input logic              vid_lock,
  input logic              vid_field,
  input logic              vid_frame,
  input logic              acc_start,
  input logic              win_done,
  input logic              ptr_wr,
  input logic [5:0]        ptr_idx,
  input logic              ptr_ai,
  input logic [FLAT_W-1:0] tx_flat
);

  // R2
  status_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 2'd1 |-> host_rdata == {vid_frame, vid_field, vid_lock, 1'b0,
                                         rx_dir, rx_lock, pin_click, pin_frame});

  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (ptr_idx == $past(host_wdata[5:0]) && ptr_ai == $past(host_wdata[7])));

  // R3
  ptr_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 2'd2 |-> host_rdata[6] == 1'b0);

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_done && !ptr_wr) |=> $stable(ptr_idx));

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && ptr_ai) |=> ptr_idx == 6'($past(ptr_idx) + 6'd1));

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && ptr_ai && ptr_idx == 6'd63) |=> ptr_idx == 6'd0);

  // R6
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && host_we && host_addr == 2'd3 && int'(ptr_idx) < RO_REGS)
      |=> $stable(tx_flat));

  // R7
  oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && host_we && host_addr == 2'd3 && int'(ptr_idx) >= NUM_REGS)
      |=> $stable(tx_flat));

  // R7
  oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 2'd3 && int'(ptr_idx) >= NUM_REGS) |-> host_rdata == 8'h00);

  // R10
  addr0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 2'd0 |-> host_rdata == 8'h00);

endmodule

bind tc_hostport tc_hostport_chk #(
  .NUM_REGS (NUM_REGS),
  .RO_REGS  (RO_REGS),
  .FLAT_W   (WR_REGS*8)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .pin_frame  (pin_frame),
  .pin_click  (pin_click),
  .rx_lock    (rx_lock),
  .rx_dir     (rx_dir),
  .vid_lock   (vid_lock),
  .vid_field  (vid_field),
  .vid_frame  (vid_frame),
  .acc_start  (acc_start),
  .win_done   (win_done),
  .ptr_wr     (ptr_wr),
  .ptr_idx    (ptr_idx),
  .ptr_ai     (ptr_ai),
  .tx_flat    (tx_flat)
);

// File: tb/tc_hostport_tb.sv
module tc_hostport_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 57;
  localparam int NRO  = 8;
  localparam int NWR  = NREG - NRO;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_stb = 1'b0;
  logic             host_we = 1'b0;
  logic [1:0]       host_addr = 2'd0;
  logic [7:0]       host_wdata = 8'h00;
  logic [7:0]       host_rdata;
  logic             pin_frame = 0, pin_click = 0, rx_lock = 0, rx_dir = 0;
  logic             vid_lock = 0, vid_field = 0, vid_frame = 0;
  logic [NRO*8-1:0] rx_word = '0;
  logic [NWR*8-1:0] tx_flat;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit run_cmp = 0;

  // behavioural model
  int       m_idx = 0;
  bit       m_ai = 0;
  bit [7:0] m_reg [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_hostport u_dut (
    .clk(clk), .rst_n(rst_n), .host_stb(host_stb), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pin_frame(pin_frame), .pin_click(pin_click), .rx_lock(rx_lock),
    .rx_dir(rx_dir), .vid_lock(vid_lock), .vid_field(vid_field),
    .vid_frame(vid_frame), .rx_word(rx_word), .tx_flat(tx_flat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] model_win();
    if (m_idx < NRO) return rx_word[m_idx*8 +: 8];
    if (m_idx < NREG) return m_reg[m_idx];
    return 8'h00;
  endfunction

  // compare stored registers against the model on every clock (R5 R6 R7)
  always @(negedge clk) begin
    if (run_cmp && !finished) begin
      for (int k = 0; k < NWR; k++) begin
        if (tx_flat[k*8 +: 8] != m_reg[NRO+k])
          check(0, $sformatf("R5 reg %0d", NRO+k), tx_flat[k*8 +: 8], m_reg[NRO+k]);
      end
      checks++;
    end
  end

  // one host access held for 'hold' clocks; returns data seen during the strobe
  task automatic access(input bit [1:0] a, input bit w, input bit [7:0] d,
                        input int hold, output bit [7:0] rd);
    @(negedge clk);
    host_addr = a; host_we = w; host_wdata = d; host_stb = 1'b1;
    @(posedge clk);
    #1;
    if (w && a == 2'd2) begin m_ai = d[7]; m_idx = d[5:0]; end
    if (w && a == 2'd3 && m_idx >= NRO && m_idx < NREG) m_reg[m_idx] = d;
    repeat (hold - 1) @(posedge clk);
    @(negedge clk);
    rd = host_rdata;
    host_stb = 1'b0; host_we = 1'b0;
    @(posedge clk);
    #1;
    if (a == 2'd3 && m_ai) m_idx = (m_idx + 1) % 64;
  endtask

  task automatic peek_ptr(input string req);
    @(negedge clk);
    host_addr = 2'd2;
    #1;
    check(host_rdata == {m_ai, 1'b0, 6'(m_idx)}, req, host_rdata, {m_ai, 1'b0, 6'(m_idx)});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    bit [7:0] rd;
    for (int k = 0; k < 64; k++) m_reg[k] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    run_cmp = 1;

    // R1 reset state
    peek_ptr("R1 pointer after reset");
    check(tx_flat == '0, "R1 storage after reset", 0, 0);

    // R2 status packing, two patterns
    @(negedge clk);
    host_addr = 2'd1;
    pin_frame = 1; pin_click = 0; rx_lock = 1; rx_dir = 0;
    vid_lock = 1; vid_field = 0; vid_frame = 1;
    #1 check(host_rdata == 8'hA5, "R2 status pattern A", host_rdata, 8'hA5);
    pin_frame = 0; pin_click = 1; rx_lock = 0; rx_dir = 1;
    vid_lock = 0; vid_field = 1; vid_frame = 0;
    #1 check(host_rdata == 8'h4A, "R2 status pattern B", host_rdata, 8'h4A);

    // R3 pointer load, bit 6 dropped
    access(2'd2, 1, 8'hCA, 1, rd);
    peek_ptr("R3 pointer readback");
    check(host_rdata == 8'h8A, "R3 reserved bit reads zero", host_rdata, 8'h8A);

    // R5 R8 burst write into 8..15 with auto-increment
    access(2'd2, 1, 8'h88, 1, rd);
    for (int k = 0; k < 8; k++) access(2'd3, 1, 8'(8'h11 * (k + 1)), 1 + (k % 3), rd);
    peek_ptr("R8 pointer after eight writes");
    check(tx_flat[63:0] == 64'h8877665544332211, "R5 transmit bytes", 0, 0);

    // R4 read back received word and stored bytes
    rx_word = 64'hF0E1D2C3B4A59687;
    access(2'd2, 1, 8'h80, 1, rd);
    for (int k = 0; k < 16; k++) begin
      bit [7:0] e;
      e = model_win();
      access(2'd3, 0, 8'h00, 1, rd);
      check(rd == e, $sformatf("R4 window read idx %0d", k), rd, e);
    end
    peek_ptr("R8 pointer after sixteen reads");

    // R8 long strobe advances once
    access(2'd3, 0, 8'h00, 12, rd);
    peek_ptr("R8 single step for long strobe");

    // R8 hold with auto-increment off
    access(2'd2, 1, 8'h14, 1, rd);
    access(2'd3, 1, 8'h3C, 1, rd);
    access(2'd3, 1, 8'h3D, 2, rd);
    peek_ptr("R8 index holds");
    check(tx_flat[12*8 +: 8] == 8'h3D, "R5 last write wins", tx_flat[12*8 +: 8], 8'h3D);

    // R6 refused write with concurrent pointer advance
    access(2'd2, 1, 8'h83, 1, rd);
    access(2'd3, 1, 8'h55, 1, rd);
    peek_ptr("R6 pointer still advances");
    // received word changes during an open read
    @(negedge clk);
    host_addr = 2'd3; host_we = 0; host_stb = 1;
    @(negedge clk);
    rx_word[39:32] = 8'h6E;
    #1 check(host_rdata == 8'h6E, "R4 live received byte", host_rdata, 8'h6E);
    host_stb = 0;
    @(posedge clk); #1 m_idx = m_idx + 1;
    peek_ptr("R8 one step after live read");

    // R7 out-of-range index
    access(2'd2, 1, 8'h39, 1, rd);
    access(2'd3, 0, 8'h00, 1, rd);
    check(rd == 8'h00, "R7 read index 57", rd, 0);
    access(2'd2, 1, 8'hBD, 1, rd);
    access(2'd3, 1, 8'hEE, 1, rd);
    access(2'd3, 0, 8'h00, 1, rd);
    check(rd == 8'h00, "R7 read index 62", rd, 0);
    // R9 wrap from 63
    access(2'd3, 1, 8'h77, 1, rd);
    peek_ptr("R9 wrap to zero");

    // R10 other direct addresses
    access(2'd0, 1, 8'hFF, 1, rd);
    access(2'd1, 1, 8'hFF, 1, rd);
    access(2'd0, 0, 8'h00, 1, rd);
    check(rd == 8'h00, "R10 address 0 reads zero", rd, 0);
    access(2'd1, 0, 8'h00, 3, rd);
    check(rd == 8'h4A, "R10 status unaffected by writes", rd, 8'h4A);
    peek_ptr("R10 pointer unmoved");

    repeat (2) @(negedge clk);
    finished = 1;
    summary();
  end

endmodule